// File: doc/BRIEF.md
# Disk Target Bus-Phase Sequencer

This block plays the target side of a parallel disk bus. It watches the initiator's control lines and data byte, and it drives its own busy line, the byte-request line and the three phase lines (message, command/data, input/output). After it recognises its own selection, it takes an optional message byte and then collects a command descriptor block one byte at a time over a request/acknowledge handshake. It decodes a small set of opcodes and steps through data, status and message phases before it releases the bus.

Data bytes move over a DMA-style stream handshake. `dma_req` works as valid and `dma_ack` as ready. Once `dma_req` is high it stays high, and `tgt_data` stays stable, until the cycle in which `dma_ack` is seen. The acknowledge clears the request, and the next byte is offered no sooner than the cycle after `dma_ack` returns low. `dma_en` low stalls the stream without losing state. Bytes for a data-in transfer come from a combinational read port (`rd_addr`/`rd_data`) whose address counter advances once per accepted byte. The one exception is the capacity reply, which the block builds itself.

Top module: `disk_target_seq`

## Requirements
- R1: A high `bus_rst` at any clock edge puts the block in bus-free state. After that edge, `tgt_bsy`, `tgt_req`, `tgt_msg`, `tgt_cd`, `tgt_io` and `dma_req` are all 0.
- R2: Selection happens only when `ini_sel`=1, `ini_bsy`=0, `ini_drive`=1 and bit 6 of `ini_data`=1 after a bus-free cycle with `ini_sel` high. The target then raises `tgt_bsy`. With bit 6 clear, or with `ini_bsy` high, `tgt_bsy` stays 0.
- R3: After selection with `ini_atn`=0, the lines become command phase: msg=0, cd=1, io=0.
- R4: After selection with `ini_atn`=1, the lines become message-out phase (msg=1, cd=1, io=0) with `tgt_req`=1. One handshake consumes a byte and the lines move to command phase.
- R5: In command phase, `tgt_req` rises while `ini_ack` is low. When `tgt_req` and `ini_ack` are both high, the byte is stored and `tgt_req` drops. The command length is set by opcode bits [7:5]: 0 means 6 bytes, 1 or 2 means 10 bytes. An unrecognised opcode never leaves command phase, and after 10 bytes `tgt_req` stays low.
- R6: The opcode decides the next step. 0x00 goes to status. 0x03, 0x12 and 0x1A go to data-in with count byte 4. 0x15 goes to data-out (io=0) with count byte 4. 0x08 goes to data-in with count byte4×512. 0x25 goes to data-in with count 8. 0x28 goes to data-in with count {byte7,byte8}×512. Data phases use cd=0.
- R7: In a data phase with `dma_en`=1, each byte is offered with `dma_req` and consumed by `dma_ack`. With `dma_en`=0, no request appears. After the last byte the lines become status (msg=0, cd=1, io=1) with `tgt_req`=0.
- R8: The 0x25 reply is 8 bytes: the parameter `LAST_LBA` most significant byte first, then 0x00, 0x00, 0x02, 0x00.
- R9: Data-in bytes are `rd_data` read at consecutive addresses. For 0x28 the first address is the big-endian bytes 2..5 times 512. For all other commands the first address is 0.
- R10: Status phase presents 0x00 with `tgt_req`. Its handshake moves to message-in (msg=1, cd=1, io=1), which presents 0x00. That handshake clears the phase lines and drops `tgt_bsy`.
- R11: A recognised command whose byte count is 0 goes straight to status and never raises `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Initiator bus reset |
| ini_sel | input | 1 | Initiator select line |
| ini_bsy | input | 1 | Initiator busy line |
| ini_atn | input | 1 | Initiator attention line |
| ini_ack | input | 1 | Initiator byte acknowledge |
| ini_drive | input | 1 | Initiator is driving the data bus |
| ini_data | input | 8 | Initiator output byte |
| dma_en | input | 1 | DMA transfer mode enable |
| dma_ack | input | 1 | DMA byte acknowledge (ready) |
| rd_data | input | 8 | Byte returned by the read port |
| tgt_bsy | output | 1 | Target busy |
| tgt_req | output | 1 | Target byte request |
| tgt_msg | output | 1 | Message phase line |
| tgt_cd | output | 1 | Command/data phase line |
| tgt_io | output | 1 | Input/output phase line |
| tgt_data | output | 8 | Byte presented by the target |
| dma_req | output | 1 | DMA byte request (valid) |
| rd_addr | output | ADDR_W | Read port address |

## Verification
If the stored descriptor or byte index is wrong, the next phase-line change is early, late or missing. That shows at the port as a command that stalls, or as the lines flipping to status before the tenth byte of a long command. A wrong transfer count shows at the last acknowledge: the status lines appear one byte early, or another `dma_req` appears where status was expected. A wrong address counter shows on the first mismatching `tgt_data` byte. A busy flag left set after message-in shows one cycle after the final acknowledge.

// File: rtl/tgt_seq_pkg.sv
package tgt_seq_pkg;
  localparam int CDB_SHORT = 6;
  localparam int CDB_LONG  = 10;
  localparam int BLK_SHIFT = 9;

  typedef enum logic [3:0] {
    PH_FREE, PH_ARB, PH_SELD, PH_MSGOUT, PH_CMD,
    PH_DIN, PH_DOUT, PH_STAT, PH_MSGIN
  } phase_t;

  typedef enum logic [1:0] {XF_NONE, XF_IN, XF_OUT} xfer_dir_t;
endpackage

// File: rtl/tgt_cdb_decode.sv
module tgt_cdb_decode
  import tgt_seq_pkg::*;
#(
  parameter int CDB_MAX = 10,
  parameter int CNT_W   = 25,
  parameter int ADDR_W  = 32
) (
  input  logic [CDB_MAX-1:0][7:0] cdb,
  output logic                    known,
  output logic                    long_cmd,
  output xfer_dir_t               dir,
  output logic [CNT_W-1:0]        count,
  output logic [ADDR_W-1:0]       start_addr,
  output logic                    cap_sel
);
  logic [31:0] lba;
  logic        unused_bytes;

  assign lba          = {cdb[2], cdb[3], cdb[4], cdb[5]};
  assign unused_bytes = ^{cdb[1], cdb[6], cdb[CDB_MAX-1:9]};
  assign long_cmd     = (cdb[0][7:5] == 3'd1) || (cdb[0][7:5] == 3'd2);

  always_comb begin
    known      = 1'b1;
    dir        = XF_IN;
    count      = CNT_W'(cdb[4]);
    start_addr = '0;
    cap_sel    = 1'b0;
    unique case (cdb[0])
      8'h00: begin dir = XF_NONE; count = '0; end
      8'h03, 8'h12, 8'h1A: ;
      8'h15: dir = XF_OUT;
      8'h08: count = CNT_W'({cdb[4], 9'b0});
      8'h25: begin count = CNT_W'(8); cap_sel = 1'b1; end
      8'h28: begin
        count      = CNT_W'({cdb[7], cdb[8], 9'b0});
        start_addr = ADDR_W'({lba, 9'b0});
      end
      default: begin known = 1'b0; dir = XF_NONE; count = '0; end
    endcase
  end
endmodule

// File: rtl/tgt_cap_reply.sv
module tgt_cap_reply #(
  parameter logic [31:0] LAST_LBA = 32'h0000_FFFF
) (
  input  logic [2:0] sel,
  output logic [7:0] byte_out
);
  localparam logic [63:0] REPLY = {LAST_LBA, 32'h0000_0200};
  assign byte_out = REPLY[63 - 8*sel -: 8];
endmodule

// File: rtl/disk_target_seq.sv
module disk_target_seq
  import tgt_seq_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          CNT_W    = 25,
  parameter int          CDB_MAX  = 10,
  parameter logic [31:0] LAST_LBA = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              ini_sel,
  input  logic              ini_bsy,
  input  logic              ini_atn,
  input  logic              ini_ack,
  input  logic              ini_drive,
  input  logic [7:0]        ini_data,
  input  logic              dma_en,
  input  logic              dma_ack,
  input  logic [7:0]        rd_data,
  output logic              tgt_bsy,
  output logic              tgt_req,
  output logic              tgt_msg,
  output logic              tgt_cd,
  output logic              tgt_io,
  output logic [7:0]        tgt_data,
  output logic              dma_req,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int IDX_W = $clog2(CDB_MAX + 1);

  phase_t                  st;
  logic [CDB_MAX-1:0][7:0] cdb;
  logic [IDX_W-1:0]        idx;
  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-1:0]       ptr;
  logic                    cap_src;

  logic                    dec_known, dec_long, dec_cap;
  xfer_dir_t               dec_dir;
  logic [CNT_W-1:0]        dec_count;
  logic [ADDR_W-1:0]       dec_addr;
  logic [7:0]              cap_byte;
  logic [IDX_W-1:0]        need_len;
  logic                    cmd_done;
  logic [7:0]              din_byte;

  tgt_cdb_decode #(.CDB_MAX(CDB_MAX), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dec (
    .cdb(cdb), .known(dec_known), .long_cmd(dec_long), .dir(dec_dir),
    .count(dec_count), .start_addr(dec_addr), .cap_sel(dec_cap)
  );

  tgt_cap_reply #(.LAST_LBA(LAST_LBA)) u_cap (
    .sel(ptr[2:0]), .byte_out(cap_byte)
  );

  assign need_len = dec_long ? IDX_W'(CDB_LONG) : IDX_W'(CDB_SHORT);
  assign cmd_done = (idx != '0) && dec_known && (idx == need_len);
  assign din_byte = cap_src ? cap_byte : rd_data;
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_FREE;
      cdb <= '0;
      idx <= '0;
      cnt <= '0;
      ptr <= '0;
      cap_src <= 1'b0;
      tgt_bsy <= 1'b0;
      tgt_req <= 1'b0;
      tgt_msg <= 1'b0;
      tgt_cd <= 1'b0;
      tgt_io <= 1'b0;
      tgt_data <= '0;
      dma_req <= 1'b0;
    end else if (bus_rst) begin
      st <= PH_FREE;
      tgt_bsy <= 1'b0;
      tgt_req <= 1'b0;
      tgt_msg <= 1'b0;
      tgt_cd <= 1'b0;
      tgt_io <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      unique case (st)
        PH_FREE: if (ini_sel) st <= PH_ARB;
        PH_ARB: begin
          if (!ini_bsy && ini_sel && ini_drive && ini_data[6]) begin
            st <= PH_SELD;
            tgt_bsy <= 1'b1;
          end else if (!ini_bsy && !ini_sel) begin
            st <= PH_FREE;
          end
        end
        PH_SELD: begin
          tgt_msg <= ini_atn;
          tgt_cd <= 1'b1;
          tgt_io <= 1'b0;
          idx <= '0;
          cdb <= '0;
          if (ini_atn) begin
            st <= PH_MSGOUT;
            tgt_req <= 1'b1;
          end else begin
            st <= PH_CMD;
          end
        end
        PH_MSGOUT: begin
          if (tgt_req && ini_ack) begin
            tgt_req <= 1'b0;
            tgt_msg <= 1'b0;
            st <= PH_CMD;
          end
        end
        PH_CMD: begin
          if (cmd_done) begin
            tgt_req <= 1'b0;
            cnt <= dec_count;
            ptr <= dec_addr;
            cap_src <= dec_cap;
            if (dec_dir == XF_NONE || dec_count == '0) begin
              st <= PH_STAT;
              tgt_io <= 1'b1;
            end else if (dec_dir == XF_IN) begin
              st <= PH_DIN;
              tgt_cd <= 1'b0;
              tgt_io <= 1'b1;
            end else begin
              st <= PH_DOUT;
              tgt_cd <= 1'b0;
            end
          end else if (!ini_ack && idx < IDX_W'(CDB_MAX)) begin
            tgt_req <= 1'b1;
          end else if (tgt_req && ini_ack) begin
            cdb[idx] <= ini_data;
            idx <= idx + 1'b1;
            tgt_req <= 1'b0;
          end
        end
        PH_DIN, PH_DOUT: begin
          if (!ini_ack) tgt_req <= 1'b1;
          if (dma_req && dma_ack) begin
            dma_req <= 1'b0;
            cnt <= cnt - 1'b1;
            ptr <= ptr + 1'b1;
            if (cnt == CNT_W'(1)) begin
              st <= PH_STAT;
              tgt_req <= 1'b0;
              tgt_cd <= 1'b1;
              tgt_io <= 1'b1;
            end
          end else if (dma_en && !dma_req && !dma_ack) begin
            tgt_data <= (st == PH_DIN) ? din_byte : 8'h00;
            dma_req <= 1'b1;
          end
        end
        PH_STAT: begin
          if (!ini_ack) begin
            tgt_data <= 8'h00;
            tgt_req <= 1'b1;
          end else if (tgt_req) begin
            tgt_req <= 1'b0;
            tgt_msg <= 1'b1;
            st <= PH_MSGIN;
          end
        end
        PH_MSGIN: begin
          if (!ini_ack) begin
            tgt_data <= 8'h00;
            tgt_req <= 1'b1;
          end else if (tgt_req) begin
            tgt_req <= 1'b0;
            tgt_msg <= 1'b0;
            tgt_cd <= 1'b0;
            tgt_io <= 1'b0;
            tgt_bsy <= 1'b0;
            st <= PH_FREE;
          end
        end
        default: st <= PH_FREE;
      endcase
    end
  end
endmodule

// File: rtl/tgt_seq_checker.sv
module tgt_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       ini_sel,
  input logic       ini_bsy,
  input logic       ini_ack,
  input logic       ini_drive,
  input logic [7:0] ini_data,
  input logic       dma_ack,
  input logic       tgt_bsy,
  input logic       tgt_req,
  input logic       tgt_msg,
  input logic       tgt_cd,
  input logic       tgt_io,
  input logic [7:0] tgt_data,
  input logic       dma_req
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !tgt_bsy && !tgt_req && !dma_req && !tgt_msg && !tgt_cd && !tgt_io);

  a_r2_bsy_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_bsy) |-> $past(ini_sel && ini_drive && ini_data[6] && !ini_bsy));

  a_r7_dma_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack && !bus_rst |=> dma_req && $stable(tgt_data));

  a_r7_dma_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !tgt_cd && !tgt_msg);

  a_r10_msg_with_cd: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_msg |-> tgt_cd);

  a_r10_bsy_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_bsy) |-> $past(bus_rst) || $past(tgt_msg && tgt_io && tgt_req && ini_ack));
endmodule

bind disk_target_seq tgt_seq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .ini_sel(ini_sel),
  .ini_bsy(ini_bsy), .ini_ack(ini_ack), .ini_drive(ini_drive),
  .ini_data(ini_data), .dma_ack(dma_ack), .tgt_bsy(tgt_bsy),
  .tgt_req(tgt_req), .tgt_msg(tgt_msg), .tgt_cd(tgt_cd), .tgt_io(tgt_io),
  .tgt_data(tgt_data), .dma_req(dma_req)
);

// File: tb/disk_target_seq_test.sv
module disk_target_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, bus_rst = 1'b0;
  logic ini_sel = 0, ini_bsy = 0, ini_atn = 0, ini_ack = 0, ini_drive = 0;
  logic [7:0] ini_data = 8'h00;
  logic dma_en = 1'b1, dma_ack = 1'b0;
  logic [7:0] rd_data;
  logic tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io, dma_req;
  logic [7:0] tgt_data;
  logic [31:0] rd_addr;

  int total = 0, fails = 0;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] cap_byte(input int i);
    logic [63:0] r;
    r = {32'h0000_FFFF, 32'h0000_0200};
    return r[63 - 8*i -: 8];
  endfunction

  assign rd_data = mem_byte(rd_addr);

  disk_target_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .ini_sel(ini_sel),
    .ini_bsy(ini_bsy), .ini_atn(ini_atn), .ini_ack(ini_ack),
    .ini_drive(ini_drive), .ini_data(ini_data), .dma_en(dma_en),
    .dma_ack(dma_ack), .rd_data(rd_data), .tgt_bsy(tgt_bsy),
    .tgt_req(tgt_req), .tgt_msg(tgt_msg), .tgt_cd(tgt_cd), .tgt_io(tgt_io),
    .tgt_data(tgt_data), .dma_req(dma_req), .rd_addr(rd_addr)
  );

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wait_req(input string r);
    int n = 0;
    while (!tgt_req) begin
      @(negedge clk);
      n++;
      if (n > 2000) begin check(0, r, 0, 1); return; end
    end
  endtask

  task automatic wait_dreq(input string r);
    int n = 0;
    while (!dma_req) begin
      @(negedge clk);
      n++;
      if (n > 2000) begin check(0, r, 0, 1); return; end
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input string r);
    wait_req(r);
    ini_data = b;
    ini_ack = 1'b1;
    @(negedge clk);
    ini_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_cdb(input logic [7:0] b [10], input int lo, input int hi);
    for (int i = lo; i < hi; i++) put_byte(b[i], "R5");
  endtask

  task automatic select(input bit atn);
    int n = 0;
    ini_bsy = 0; ini_sel = 1; ini_drive = 1; ini_data = 8'h41; ini_atn = atn;
    @(negedge clk);
    while (!tgt_bsy && n < 50) begin @(negedge clk); n++; end
    check(tgt_bsy, "R2", tgt_bsy, 1);
    ini_sel = 0; ini_drive = 0;
    @(negedge clk);
    ini_atn = 0;
    if (atn) begin
      check({tgt_msg, tgt_cd, tgt_io, tgt_req} == 4'b1101, "R4",
            {tgt_msg, tgt_cd, tgt_io, tgt_req}, 4'b1101);
      put_byte(8'h80, "R4");
    end
    check({tgt_msg, tgt_cd, tgt_io} == 3'b010, "R3", {tgt_msg, tgt_cd, tgt_io}, 3'b010);
  endtask

  task automatic data_in(input int n, input logic [31:0] base, input bit cap, input string r);
    int bad = 0;
    logic [7:0] a0 = 0, e0 = 0, e;
    for (int i = 0; i < n; i++) begin
      wait_dreq(r);
      e = cap ? cap_byte(i) : mem_byte(base + i);
      if (tgt_data !== e || tgt_cd || !tgt_io) begin
        if (bad == 0) begin a0 = tgt_data; e0 = e; end
        bad++;
      end
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
    end
    check(bad == 0, r, a0, e0);
    check({tgt_msg, tgt_cd, tgt_io, tgt_req, dma_req} == 5'b01100, "R7",
          {tgt_msg, tgt_cd, tgt_io, tgt_req, dma_req}, 5'b01100);
  endtask

  task automatic data_out(input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      wait_dreq("R6");
      if (tgt_io || tgt_cd) bad++;
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
    end
    check(bad == 0, "R6", bad, 0);
    check({tgt_cd, tgt_io} == 2'b11, "R7", {tgt_cd, tgt_io}, 2'b11);
  endtask

  task automatic status_msg();
    wait_req("R10");
    check({tgt_msg, tgt_cd, tgt_io} == 3'b011 && tgt_data == 8'h00, "R10",
          {tgt_msg, tgt_cd, tgt_io, tgt_data}, 11'h300);
    ini_ack = 1'b1;
    @(negedge clk);
    check({tgt_msg, tgt_cd, tgt_io, tgt_req} == 4'b1110, "R10",
          {tgt_msg, tgt_cd, tgt_io, tgt_req}, 4'b1110);
    ini_ack = 1'b0;
    wait_req("R10");
    check(tgt_data == 8'h00, "R10", tgt_data, 0);
    ini_ack = 1'b1;
    @(negedge clk);
    check({tgt_bsy, tgt_msg, tgt_cd, tgt_io} == 4'b0000, "R10",
          {tgt_bsy, tgt_msg, tgt_cd, tgt_io}, 0);
    ini_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    logic [7:0] c [10];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io, dma_req} == 0, "R1",
          {tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io, dma_req}, 0);

    // R2: bit 6 clear, then initiator busy: no selection
    ini_sel = 1; ini_drive = 1; ini_data = 8'h01;
    repeat (10) @(negedge clk);
    check(!tgt_bsy, "R2", tgt_bsy, 0);
    ini_data = 8'h40; ini_bsy = 1;
    repeat (10) @(negedge clk);
    check(!tgt_bsy, "R2", tgt_bsy, 0);
    ini_sel = 0; ini_drive = 0; ini_bsy = 0;
    repeat (3) @(negedge clk);

    // R6 opcode 0x00 straight to status
    select(0);
    c = '{default: 8'h00};
    send_cdb(c, 0, 6);
    check({tgt_cd, tgt_io, dma_req} == 3'b110, "R6", {tgt_cd, tgt_io, dma_req}, 3'b110);
    status_msg();

    // R4 message-out then inquiry, with dma_en gating (R7), R9 base 0
    select(1);
    c = '{8'h12, 8'h00, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    dma_en = 1'b0;
    send_cdb(c, 0, 6);
    repeat (20) @(negedge clk);
    check(!dma_req && !tgt_cd && tgt_io, "R7", {dma_req, tgt_cd, tgt_io}, 3'b001);
    dma_en = 1'b1;
    data_in(5, 32'h0, 1'b0, "R9");
    status_msg();

    // R8 capacity reply; R5 long command still waiting after 6 bytes
    select(0);
    c = '{8'h25, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_cdb(c, 0, 6);
    repeat (4) @(negedge clk);
    check({tgt_cd, tgt_io, dma_req} == 3'b100, "R5", {tgt_cd, tgt_io, dma_req}, 3'b100);
    send_cdb(c, 6, 10);
    data_in(8, 32'h0, 1'b1, "R8");
    status_msg();

    // R9 read(10): LBA 0x00000102, one block
    select(0);
    c = '{8'h28, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00};
    send_cdb(c, 0, 10);
    data_in(512, 32'h0002_0400, 1'b0, "R9");
    status_msg();

    // R6 read(6): one block from address 0
    select(0);
    c = '{8'h08, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_cdb(c, 0, 6);
    data_in(512, 32'h0, 1'b0, "R6");
    status_msg();

    // R6 data-out, 3 bytes
    select(0);
    c = '{8'h15, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_cdb(c, 0, 6);
    data_out(3);
    status_msg();

    // R11 zero count goes straight to status
    select(0);
    c = '{8'h1A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_cdb(c, 0, 6);
    check({tgt_cd, tgt_io, dma_req} == 3'b110, "R11", {tgt_cd, tgt_io, dma_req}, 3'b110);
    status_msg();

    // R5 unknown opcode stalls; then R1 bus reset
    select(0);
    c = '{8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    send_cdb(c, 0, 10);
    repeat (20) @(negedge clk);
    check({tgt_req, tgt_msg, tgt_cd, tgt_io, tgt_bsy} == 5'b00101, "R5",
          {tgt_req, tgt_msg, tgt_cd, tgt_io, tgt_bsy}, 5'b00101);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    check({tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io, dma_req} == 0, "R1",
          {tgt_bsy, tgt_req, tgt_msg, tgt_cd, tgt_io, dma_req}, 0);

    // R1 mid-transfer reset drops the stream request
    select(0);
    c = '{8'h03, 8'h00, 8'h00, 8'h00, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    send_cdb(c, 0, 6);
    wait_dreq("R6");
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    check({tgt_bsy, dma_req, tgt_io} == 0, "R1", {tgt_bsy, dma_req, tgt_io}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule